// File: doc/BRIEF.md
# Pipelined Hyperbolic Sine/Cosine Unit

This block evaluates the hyperbolic cosine and sine of a signed fixed-point angle with the CORDIC method in hyperbolic rotation form. Every micro-rotation has its own register stage, so a new argument can enter on every clock and one result leaves on every clock. Values are two's complement with 16 fractional bits: 65536 stands for 1.0, and the angle is in radians on the same scale.

The argument is loaded into x = 1/K (the inverse of the total hyperbolic gain), y = 0 and z = angle. Stage j then applies a shift taken from the sequence 1, 2, 3, 4, 4, 5, ..., 13, 13, 14, 15, 16. Shifts 4 and 13 appear twice, which the hyperbolic iteration needs in order to converge, so there are 18 stages for the 16 base iterations. Each stage picks its direction from the sign of the residual angle and moves z toward zero by the stored constant atanh(2^-shift). When the last stage is done, x holds cosh, y holds sinh and z holds the leftover angle. A valid bit travels alongside each datum, so gaps in the input stream come out as gaps in the output stream.

Top module: `hcordic_pipe`

## Requirements
- R1: A synchronous active-high reset clears o_vld, o_cosh, o_sinh and o_resid to zero. It also discards every argument still in the pipeline, so no result for those arguments ever appears.
- R2: An argument presented with i_vld high is captured on a rising edge. Its result is shown with o_vld high after the 19th rising edge, counting the capturing edge as the first.
- R3: One argument is accepted on every clock with no stall. Arguments sent back to back produce results on consecutive clocks in the order they arrived.
- R4: A clock with i_vld low gives a clock with o_vld low in the matching output slot, whatever value i_arg has during that clock.
- R5: For |i_arg| <= 73000 (about 1.114 rad), o_cosh lies within 64 LSB of cosh(i_arg/65536)*65536.
- R6: For |i_arg| <= 73000, o_sinh lies within 64 LSB of sinh(i_arg/65536)*65536 and carries the argument's sign.
- R7: For |i_arg| <= 73000, the residual angle o_resid has magnitude of at most 8 LSB.
- R8: A zero argument yields o_cosh within 64 LSB of 65536 and o_sinh within 64 LSB of 0.
- R9: For any 32-bit argument, including ones outside the convergence range, a valid result has o_cosh > 0 and o_cosh > |o_sinh|.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| i_vld | input | 1 | Marks i_arg as a real argument in this clock |
| i_arg | input | 32 | Signed angle in radians, 16 fractional bits |
| o_vld | output | 1 | Marks the result outputs as valid |
| o_cosh | output | 32 | Signed hyperbolic cosine, 16 fractional bits |
| o_sinh | output | 32 | Signed hyperbolic sine, 16 fractional bits |
| o_resid | output | 32 | Angle left over after the last stage, 16 fractional bits |

## Verification
The hardest case to reach is a reset that arrives while results are still moving through the 18 stages. The stimulus loads ten arguments back to back, raises reset before any of them can come out, and then watches more than a full pipeline depth of clocks for a stray valid. A second difficult area is the edge of the convergence range together with wildly out-of-range arguments. The bench sweeps the argument densely from -73000 to +73000, including both end points, and then sends the extreme 32-bit values, where it checks only the cosh-over-sinh ordering. Interleaved idle clocks carry junk on the argument input, which shows that bubbles line up at the output.

// File: rtl/hcordic_pkg.sv
package hcordic_pkg;

  // Fractional bits of every operand; the angle constants below assume 16.
  localparam int FRAC = 16;

  // Inverse of the total hyperbolic gain (stages 1..16 with 4 and 13 doubled), Q16.
  localparam int KINV_Q16 = 79135;

  // Shift values whose micro-rotation must run twice to converge.
  function automatic bit is_repeat(input int s);
    return (s == 4) || (s == 13) || (s == 40);
  endfunction

  // Physical stage count for a given number of base iterations.
  function automatic int stage_count(input int niter);
    int n;
    n = niter;
    for (int s = 1; s <= niter; s++) begin
      if (is_repeat(s)) n++;
    end
    return n;
  endfunction

  // Shift applied by physical stage j (j counts from 0).
  function automatic int shift_of(input int j);
    int s;
    bit again;
    s = 1;
    again = 1'b0;
    for (int k = 0; k < j; k++) begin
      if (is_repeat(s) && !again) begin
        again = 1'b1;
      end else begin
        s++;
        again = 1'b0;
      end
    end
    return s;
  endfunction

  // atanh(2^-s) in Q16. Past s = 8 the value equals 2^-s to within rounding.
  function automatic int atanh_q16(input int s);
    int r;
    case (s)
      1:       r = 35999;
      2:       r = 16739;
      3:       r = 8235;
      4:       r = 4101;
      5:       r = 2049;
      6:       r = 1024;
      7:       r = 512;
      8:       r = 256;
      default: r = (s <= FRAC) ? (1 << (FRAC - s)) : 0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hcordic_prep.sv
module hcordic_prep #(
  parameter int DW   = 32,
  parameter int KINV = 79135
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_vld,
  input  logic signed [DW-1:0] i_arg,
  output logic                 o_vld,
  output logic signed [DW-1:0] o_x,
  output logic signed [DW-1:0] o_y,
  output logic signed [DW-1:0] o_z
);

  localparam logic signed [DW-1:0] SEED_X = DW'(KINV);

  // Seed register: x is pre-scaled by 1/K so the outputs need no final multiply.
  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_x   <= '0;
      o_y   <= '0;
      o_z   <= '0;
    end else begin
      o_vld <= i_vld;
      o_x   <= SEED_X;
      o_y   <= '0;
      o_z   <= i_arg;
    end
  end

  AST_SEED_VLD_FWD: assert property (@(posedge clk) disable iff (rst)
    i_vld |=> o_vld);  // R2

endmodule

// File: rtl/hcordic_stage.sv
module hcordic_stage #(
  parameter int DW    = 32,
  parameter int SHIFT = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_vld,
  input  logic signed [DW-1:0] i_x,
  input  logic signed [DW-1:0] i_y,
  input  logic signed [DW-1:0] i_z,
  output logic                 o_vld,
  output logic signed [DW-1:0] o_x,
  output logic signed [DW-1:0] o_y,
  output logic signed [DW-1:0] o_z
);

  localparam logic signed [DW-1:0] ANG = DW'(hcordic_pkg::atanh_q16(SHIFT));

  logic signed [DW-1:0] x_sh;
  logic signed [DW-1:0] y_sh;
  logic                 z_nonneg;

  always_comb begin
    x_sh     = i_x >>> SHIFT;
    y_sh     = i_y >>> SHIFT;
    z_nonneg = ~i_z[DW-1];
  end

  // Hyperbolic micro-rotation: both cross terms carry the same sign.
  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_x   <= '0;
      o_y   <= '0;
      o_z   <= '0;
    end else begin
      o_vld <= i_vld;
      if (z_nonneg) begin
        o_x <= i_x + y_sh;
        o_y <= i_y + x_sh;
        o_z <= i_z - ANG;
      end else begin
        o_x <= i_x - y_sh;
        o_y <= i_y - x_sh;
        o_z <= i_z + ANG;
      end
    end
  end

  AST_VLD_FWD: assert property (@(posedge clk) disable iff (rst)
    i_vld |=> o_vld);  // R3

  AST_VLD_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    !i_vld |=> !o_vld);  // R4

endmodule

// File: rtl/hcordic_pipe.sv
module hcordic_pipe #(
  parameter int DW    = 32,
  parameter int NITER = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_vld,
  input  logic signed [DW-1:0] i_arg,
  output logic                 o_vld,
  output logic signed [DW-1:0] o_cosh,
  output logic signed [DW-1:0] o_sinh,
  output logic signed [DW-1:0] o_resid
);

  localparam int NSTG = hcordic_pkg::stage_count(NITER);

  logic                 vld_c [NSTG+1];
  logic signed [DW-1:0] x_c   [NSTG+1];
  logic signed [DW-1:0] y_c   [NSTG+1];
  logic signed [DW-1:0] z_c   [NSTG+1];

  hcordic_prep #(
    .DW   (DW),
    .KINV (hcordic_pkg::KINV_Q16)
  ) u_prep (
    .clk   (clk),
    .rst   (rst),
    .i_vld (i_vld),
    .i_arg (i_arg),
    .o_vld (vld_c[0]),
    .o_x   (x_c[0]),
    .o_y   (y_c[0]),
    .o_z   (z_c[0])
  );

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    hcordic_stage #(
      .DW    (DW),
      .SHIFT (hcordic_pkg::shift_of(g))
    ) u_stage (
      .clk   (clk),
      .rst   (rst),
      .i_vld (vld_c[g]),
      .i_x   (x_c[g]),
      .i_y   (y_c[g]),
      .i_z   (z_c[g]),
      .o_vld (vld_c[g+1]),
      .o_x   (x_c[g+1]),
      .o_y   (y_c[g+1]),
      .o_z   (z_c[g+1])
    );
  end

  // Last stage registers are the outputs.
  assign o_vld   = vld_c[NSTG];
  assign o_cosh  = x_c[NSTG];
  assign o_sinh  = y_c[NSTG];
  assign o_resid = z_c[NSTG];

  logic signed [DW-1:0] sinh_mag;
  assign sinh_mag = o_sinh[DW-1] ? -o_sinh : o_sinh;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!o_vld && o_cosh == '0 && o_sinh == '0 && o_resid == '0));  // R1

  AST_HYP_ORDER: assert property (@(posedge clk) disable iff (rst)
    o_vld |-> (o_cosh > 0 && o_cosh > sinh_mag));  // R9

endmodule

// File: tb/tb_hcordic_pipe.sv
`timescale 1ns/1ps
module tb_hcordic_pipe;

  localparam int  DW      = 32;
  localparam int  LAT     = 19;
  localparam real TOL     = 64.0;
  localparam int  ZTOL    = 8;
  localparam int  INRANGE = 73000;
  localparam int  QD      = 4096;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 i_vld = 1'b0;
  logic signed [DW-1:0] i_arg = '0;
  logic                 o_vld;
  logic signed [DW-1:0] o_cosh;
  logic signed [DW-1:0] o_sinh;
  logic signed [DW-1:0] o_resid;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int wp = 0;
  int rp = 0;
  int q_arg [QD];
  int q_due [QD];
  bit finished = 1'b0;

  int  m_a;
  real m_r;
  real m_c;
  real m_s;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hcordic_pipe #(.DW(DW), .NITER(16)) dut (
    .clk     (clk),
    .rst     (rst),
    .i_vld   (i_vld),
    .i_arg   (i_arg),
    .o_vld   (o_vld),
    .o_cosh  (o_cosh),
    .o_sinh  (o_sinh),
    .o_resid (o_resid)
  );

  function automatic longint absv(input logic signed [DW-1:0] v);
    return (v < 0) ? -longint'(v) : longint'(v);
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic near(input string tag, input string what, input int act, input real exp);
    total++;
    if ($itor(act) - exp > TOL || exp - $itor(act) > TOL) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0.2f", tag, what, act, exp);
    end
  endtask

  task automatic send(input int a);
    @(negedge clk);
    i_vld = 1'b1;
    i_arg = a;
    q_arg[wp % QD] = a;
    q_due[wp % QD] = cyc + LAT;
    wp++;
  endtask

  task automatic idle();
    @(negedge clk);
    i_vld = 1'b0;
    i_arg = 32'h5a5a_7e01;
  endtask

  // Scoreboard: results must come out in order, on the due edge, and be accurate.
  always @(negedge clk) begin
    if (!rst) begin
      if (o_vld) begin
        if (rp == wp) begin
          check("R4", 1'b0, "unexpected output valid", 1, 0);
        end else begin
          m_a = q_arg[rp % QD];
          check("R2", cyc == q_due[rp % QD], "result edge", cyc, q_due[rp % QD]);
          rp++;
          check("R9", o_cosh > 0 && longint'(o_cosh) > absv(o_sinh), "cosh over |sinh|",
                o_cosh, absv(o_sinh));
          if (m_a <= INRANGE && m_a >= -INRANGE) begin
            m_r = $itor(m_a) / 65536.0;
            m_c = ($exp(m_r) + $exp(-m_r)) * 0.5 * 65536.0;
            m_s = ($exp(m_r) - $exp(-m_r)) * 0.5 * 65536.0;
            near("R5", "cosh", o_cosh, m_c);
            near("R6", "sinh", o_sinh, m_s);
            check("R7", absv(o_resid) <= ZTOL, "residual magnitude", absv(o_resid), ZTOL);
            if (m_a == 0) begin
              near("R8", "cosh at zero", o_cosh, 65536.0);
              near("R8", "sinh at zero", o_sinh, 0.0);
            end
          end
        end
      end else if (rp != wp && q_due[rp % QD] <= cyc) begin
        check("R2", 1'b0, "missing result at edge", cyc, q_due[rp % QD]);
        rp++;
      end
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check("R1", o_vld == 1'b0, "valid in reset", o_vld, 0);
    check("R1", o_cosh == 0, "cosh in reset", o_cosh, 0);
    check("R1", o_sinh == 0, "sinh in reset", o_sinh, 0);
    check("R1", o_resid == 0, "residual in reset", o_resid, 0);
    rst = 1'b0;

    // Fixed points, including zero and both range ends (R8, R5, R6).
    send(0);
    send(65536);
    send(-65536);
    send(32768);
    send(INRANGE);
    send(-INRANGE);

    // Dense back-to-back sweep (R3).
    for (int a = -INRANGE; a <= INRANGE; a += 97) send(a);

    // Sweep with bubbles carrying junk on the argument (R4).
    for (int k = 0; k < 120; k++) begin
      if (k % 3 == 1) idle();
      else send(-INRANGE + k * 1217);
    end

    // Out-of-range arguments: only the ordering property applies (R9).
    send(100000);
    send(-100000);
    send(32'sh7fff_ffff);
    send(32'sh8000_0000);
    send(16777216);

    repeat (25) idle();
    check("R4", rp == wp, "all results drained", wp - rp, 0);

    // Reset with results in flight (R1).
    for (int k = 0; k < 10; k++) send(k * 5000);
    @(negedge clk);
    rst = 1'b1;
    i_vld = 1'b0;
    @(negedge clk);
    rp = wp;
    check("R1", o_vld == 1'b0, "valid during mid-stream reset", o_vld, 0);
    @(negedge clk);
    rst = 1'b0;
    seen = 0;
    repeat (25) begin
      idle();
      if (o_vld) seen++;
    end
    check("R1", seen == 0, "flushed results reappearing", seen, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule